// File: doc/BRIEF.md
# Command Issue and Stall Controller

This block sits at the head of a command-driven data unit. It takes 128-bit quadwords from an upstream queue, splits each into four 32-bit command words (lowest word first), and issues them one per cycle. Every issued word is copied to a code register and decoded into a one-hot execute strobe for the unit that carries out the command. The execution itself belongs to those downstream units.

Issue is gated by three sticky stall bits: an operand-tag error, an undefined-command error and an interrupt stall. Each has a mask bit that keeps it from being raised. A word with its interrupt flag set is held back on first decode; a loop-prevention flag lets the same word run when it is decoded again. The marker command is the exception and runs at once. Several commands exist only on the unit with instance number 1; on any other instance they decode as undefined. Software clears the stall bits through a write-one-to-clear input and sets the masks through a small write port.

Command word layout: bit 31 interrupt flag, bits 30:24 command code, bits 23:16 count, bits 15:0 immediate. State codes: 0 idle, 1 decode, 2 stall. Strobe bits and codes: 0 nop 0x00, 1 cycle 0x01, 2 offset 0x02*, 3 base 0x03*, 4 itop 0x04, 5 mode 0x05, 6 pathmask 0x06*, 7 marker 0x07, 8 flush-end 0x10, 9 flush 0x11*, 10 flush-all 0x13*, 11 call 0x14, 12 call-flush 0x15*, 13 continue 0x17, 14 load-mask 0x20, 15 row 0x30, 16 column 0x31, 17 program 0x4A, 18 direct 0x50, 19 direct-hl 0x51, 20 unpack 0x60 to 0x7F (* instance 1 only). Any other code is undefined.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: Each word of a held quadword is issued in order bits 31:0, 63:32, 95:64, 127:96; a valid command raises exactly the strobe bit listed above, and code_word shows the issued word, both in the cycle after issue.
- R2: With no quadword held, in_ready is high and state and status bits do not change.
- R3: While er0, er1 or pis is set and a word is held, state is 2, no strobe fires and the word is not consumed.
- R4: Writing 1 to a bit of stat_clr (bit 0 er0, bit 1 er1, bit 2 pis, bit 3 int_flag) clears it, and a stalled word issues on the following cycle.
- R5: A new interrupt-flagged word other than the marker sets int_flag, sets pis when mask bit 2 is clear, moves state to 2 and fires no strobe.
- R6: An interrupt-flagged marker word sets int_flag and its strobe fires at once.
- R7: A suspended interrupt-flagged word issues exactly once when decoded again after the stall clears.
- R8: With mask bit 2 set, an interrupt-flagged word sets int_flag, leaves pis clear and still issues.
- R9: On an instance whose UNIT_ID is not 1, the instance-1-only codes decode as undefined.
- R10: An undefined word with mask bit 1 clear sets er1, moves state to 2 and is skipped; the next word issues after er1 clears.
- R11: An undefined word with mask bit 1 set leaves er1 clear, returns state to 0 and is skipped.
- R12: A tag_err pulse sets er0 only when mask bit 0 is clear, and the following issue stalls.
- R13: After reset, state is 0, all status bits and the loop-prevention flag are clear and no strobe fires.
- R14: After a command issues, state is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_qw | input | 128 | Quadword of four command words |
| in_valid | input | 1 | in_qw is valid |
| in_ready | output | 1 | Quadword buffer is empty |
| mask_wr | input | 1 | Write strobe for the mask bits |
| mask_wdata | input | 3 | New masks: bit 0 tag error, bit 1 undefined, bit 2 interrupt |
| stat_clr | input | 4 | Write-one-to-clear for er0, er1, pis, int_flag |
| tag_err | input | 1 | Tag word met where an operand was expected |
| mask | output | 3 | Current mask bits |
| state | output | 2 | Processing state |
| er0 | output | 1 | Tag error stall bit |
| er1 | output | 1 | Undefined-command stall bit |
| pis | output | 1 | Interrupt stall bit |
| int_flag | output | 1 | Interrupt seen |
| code_word | output | 32 | Last fetched command word |
| exec_strobe | output | 21 | One-hot execute strobes |

## Verification
A wrong stall bit or state shows at the ports within one cycle: the state output moves to 2 and strobes stop, or a strobe fires that should have been held. A loop-prevention flag stuck high lets an interrupt-flagged word through with no suspension, and one stuck low holds it forever; both change the strobe sequence the scoreboard expects, no later than the first decode after the stall clears. A word pointer out of step shows as a strobe out of order or a word issued twice.

// File: rtl/cmd_issue_ctrl.sv
module cmd_issue_ctrl #(
  parameter int UNIT_ID = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [127:0] in_qw,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         mask_wr,
  input  logic [2:0]   mask_wdata,
  input  logic [3:0]   stat_clr,
  input  logic         tag_err,
  output logic [2:0]   mask,
  output logic [1:0]   state,
  output logic         er0,
  output logic         er1,
  output logic         pis,
  output logic         int_flag,
  output logic [31:0]  code_word,
  output logic [20:0]  exec_strobe
);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_DEC = 2'd1, ST_STALL = 2'd2;
  localparam logic [6:0] CMD_MARK = 7'h07;
  localparam bit U1 = (UNIT_ID == 1);

  logic [127:0] qb;
  logic         qv;
  logic [1:0]   wp;
  logic         noloop;
  logic [31:0]  word;
  logic [6:0]   icmd;
  logic [4:0]   idx;
  logic         ok;
  logic         blocked, issue, new_int, susp, go, bad, consume;

  assign in_ready = !qv;
  assign word     = qb[{wp, 5'b0} +: 32];
  assign icmd     = word[30:24];
  assign blocked  = er0 | er1 | pis;
  assign issue    = qv && !blocked;
  assign new_int  = issue && word[31] && !noloop;
  assign susp     = new_int && icmd != CMD_MARK;
  assign go       = issue && !susp && ok;
  assign bad      = issue && !susp && !ok;
  assign consume  = go | bad;

  always_comb begin
    ok  = 1'b1;
    idx = 5'd0;
    casez (icmd)
      7'h00: idx = 5'd0;
      7'h01: idx = 5'd1;
      7'h02: begin idx = 5'd2;  ok = U1; end
      7'h03: begin idx = 5'd3;  ok = U1; end
      7'h04: idx = 5'd4;
      7'h05: idx = 5'd5;
      7'h06: begin idx = 5'd6;  ok = U1; end
      7'h07: idx = 5'd7;
      7'h10: idx = 5'd8;
      7'h11: begin idx = 5'd9;  ok = U1; end
      7'h13: begin idx = 5'd10; ok = U1; end
      7'h14: idx = 5'd11;
      7'h15: begin idx = 5'd12; ok = U1; end
      7'h17: idx = 5'd13;
      7'h20: idx = 5'd14;
      7'h30: idx = 5'd15;
      7'h31: idx = 5'd16;
      7'h4A: idx = 5'd17;
      7'h50: idx = 5'd18;
      7'h51: idx = 5'd19;
      7'b11?????: idx = 5'd20;
      default: ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qb <= '0; qv <= 1'b0; wp <= 2'd0;
    end else if (!qv) begin
      if (in_valid) begin
        qb <= in_qw; qv <= 1'b1; wp <= 2'd0;
      end
    end else if (consume) begin
      wp <= wp + 2'd1;
      if (wp == 2'd3) qv <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0; state <= ST_IDLE; noloop <= 1'b0;
      er0 <= 1'b0; er1 <= 1'b0; pis <= 1'b0; int_flag <= 1'b0;
      code_word <= '0; exec_strobe <= '0;
    end else begin
      if (mask_wr) mask <= mask_wdata;
      er0      <= (er0 & !stat_clr[0]) | (tag_err & !mask[0]);
      er1      <= (er1 & !stat_clr[1]) | (bad & !mask[1]);
      pis      <= (pis & !stat_clr[2]) | (new_int & !mask[2]);
      int_flag <= (int_flag & !stat_clr[3]) | new_int;
      if (susp)         noloop <= 1'b1;
      else if (consume) noloop <= 1'b0;
      if (qv) code_word <= word;
      exec_strobe <= go ? (21'd1 << idx) : 21'd0;
      if (qv && (blocked || susp)) state <= ST_STALL;
      else if (bad)                state <= mask[1] ? ST_IDLE : ST_STALL;
      else if (go)                 state <= ST_DEC;
    end
  end
endmodule

module cmd_issue_ctrl_chk #(
  parameter int UNIT_ID = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        qv,
  input logic        tag_err,
  input logic [2:0]  mask,
  input logic [1:0]  state,
  input logic        er0,
  input logic        er1,
  input logic        pis,
  input logic        noloop,
  input logic [20:0] exec_strobe
);
  localparam logic [20:0] U1_ONLY = 21'b0_0000_0001_0110_0100_1100;

  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exec_strobe));
  assert_state_legal_R14: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);
  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (qv && (er0 || er1 || pis)) |=> (state == 2'd2 && exec_strobe == '0));
  assert_er0_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(er0) |-> $past(tag_err && !mask[0]));
  assert_er1_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(er1) |-> $past(!mask[1]));
  assert_pis_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pis) |-> ($past(!mask[2]) && $past(!noloop)));
  assert_unit_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (UNIT_ID != 1) |-> ((exec_strobe & U1_ONLY) == '0));
endmodule

bind cmd_issue_ctrl cmd_issue_ctrl_chk #(.UNIT_ID(UNIT_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .qv(qv), .tag_err(tag_err), .mask(mask),
  .state(state), .er0(er0), .er1(er1), .pis(pis), .noloop(noloop),
  .exec_strobe(exec_strobe)
);

// File: tb/cmd_issue_ctrl_bench.sv
module cmd_issue_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [127:0] in_qw = '0;
  logic in_valid = 1'b0, mask_wr = 1'b0, tag_err = 1'b0;
  logic [2:0] mask_wdata = '0;
  logic [3:0] stat_clr = '0;
  logic in_ready, er0, er1, pis, int_flag;
  logic [2:0] mask;
  logic [1:0] state;
  logic [31:0] code_word;
  logic [20:0] exec_strobe;

  cmd_issue_ctrl #(.UNIT_ID(1)) u_cmd_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .in_qw(in_qw), .in_valid(in_valid), .in_ready(in_ready),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .stat_clr(stat_clr), .tag_err(tag_err),
    .mask(mask), .state(state), .er0(er0), .er1(er1), .pis(pis), .int_flag(int_flag),
    .code_word(code_word), .exec_strobe(exec_strobe));

  logic [127:0] b_qw = '0;
  logic b_valid = 1'b0;
  logic b_ready, b_er0, b_er1, b_pis, b_int;
  logic [2:0] b_mask;
  logic [1:0] b_state;
  logic [31:0] b_code;
  logic [20:0] b_strobe;

  cmd_issue_ctrl #(.UNIT_ID(0)) u_cmd_issue_ctrl_unit0 (
    .clk(clk), .rst_n(rst_n), .in_qw(b_qw), .in_valid(b_valid), .in_ready(b_ready),
    .mask_wr(1'b0), .mask_wdata(3'd0), .stat_clr(4'd0), .tag_err(1'b0),
    .mask(b_mask), .state(b_state), .er0(b_er0), .er1(b_er1), .pis(b_pis), .int_flag(b_int),
    .code_word(b_code), .exec_strobe(b_strobe));

  int tests = 0, fails = 0, b_strobes = 0;
  logic [52:0] exp_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic expect_cmd(int bit_no, logic [31:0] w);
    exp_q.push_back({21'd1 << bit_no, w});
  endtask

  always @(negedge clk) begin
    if (rst_n && exec_strobe != '0) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected strobe actual=%h/%h expected=none", exec_strobe, code_word);
      end else begin
        logic [52:0] e;
        e = exp_q.pop_front();
        if ({exec_strobe, code_word} !== e) begin
          fails++;
          $display("FAIL R1 strobe/word actual=%h/%h expected=%h/%h",
                   exec_strobe, code_word, e[52:32], e[31:0]);
        end
      end
    end
    if (rst_n && b_strobe != '0) b_strobes++;
  end

  task automatic push_qw(logic [31:0] w0, w1, w2, w3);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_qw = {w3, w2, w1, w0};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_mask(logic [2:0] v);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = v;
    @(negedge clk); mask_wr = 1'b0;
  endtask

  task automatic clear(logic [3:0] v);
    @(negedge clk); stat_clr = v;
    @(negedge clk); stat_clr = '0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state, R2 idle queue
    chk("R13 state", 32'(state), 32'd0);
    chk("R13 status", {28'd0, er0, er1, pis, int_flag}, 32'd0);
    chk("R13 strobe", 32'(exec_strobe), 32'd0);
    chk("R2 in_ready", 32'(in_ready), 32'd1);
    settle();
    chk("R2 state held", 32'(state), 32'd0);

    // R1 order and decode, R14 decode state
    expect_cmd(0, 32'h0000_0000); expect_cmd(1, 32'h0100_1234);
    expect_cmd(2, 32'h0200_0001); expect_cmd(20, 32'h6C05_0010);
    push_qw(32'h0000_0000, 32'h0100_1234, 32'h0200_0001, 32'h6C05_0010);
    settle();
    chk("R14 state after issue", 32'(state), 32'd1);
    chk("R1 queue drained", 32'(exp_q.size()), 32'd0);

    // R10 undefined word, mask clear
    push_qw(32'h0800_0000, 32'h3000_0000, 32'h3100_0000, 32'h5000_0000);
    settle();
    chk("R10 er1 set", 32'(er1), 32'd1);
    chk("R10 state stall", 32'(state), 32'd2);
    chk("R3 held, ready low", 32'(in_ready), 32'd0);
    expect_cmd(15, 32'h3000_0000); expect_cmd(16, 32'h3100_0000);
    expect_cmd(18, 32'h5000_0000);
    clear(4'b0010);
    settle();
    chk("R4 er1 cleared", 32'(er1), 32'd0);
    chk("R4 resumed", 32'(exp_q.size()), 32'd0);

    // R11 undefined word, mask set
    set_mask(3'b010);
    push_qw(32'h0900_0000, 32'h0A00_0000, 32'h0B00_0000, 32'h0C00_0000);
    settle();
    chk("R11 er1 clear", 32'(er1), 32'd0);
    chk("R11 state idle", 32'(state), 32'd0);
    expect_cmd(4, 32'h0400_0000); expect_cmd(5, 32'h0500_0000);
    expect_cmd(7, 32'h0700_0000); expect_cmd(19, 32'h5100_0000);
    push_qw(32'h0400_0000, 32'h0500_0000, 32'h0700_0000, 32'h5100_0000);
    settle();
    chk("R11 later words issue", 32'(exp_q.size()), 32'd0);
    set_mask(3'b000);

    // R5 suspend, R7 resume
    push_qw(32'h8400_0000, 32'h1000_0000, 32'h1400_0000, 32'h1700_0000);
    settle();
    chk("R5 int set", 32'(int_flag), 32'd1);
    chk("R5 pis set", 32'(pis), 32'd1);
    chk("R5 state stall", 32'(state), 32'd2);
    expect_cmd(4, 32'h8400_0000); expect_cmd(8, 32'h1000_0000);
    expect_cmd(11, 32'h1400_0000); expect_cmd(13, 32'h1700_0000);
    clear(4'b0100);
    settle();
    chk("R7 resumed once", 32'(exp_q.size()), 32'd0);
    chk("R7 state decode", 32'(state), 32'd1);
    clear(4'b1000);
    chk("R4 int cleared", 32'(int_flag), 32'd0);

    // R6 interrupt-flagged marker runs at once
    expect_cmd(7, 32'h8700_0000);
    push_qw(32'h8700_0000, 32'h2000_0000, 32'h4A00_0000, 32'h5100_0000);
    settle();
    chk("R6 marker issued", 32'(exp_q.size()), 32'd0);
    chk("R6 int set", 32'(int_flag), 32'd1);
    chk("R6 pis stalls rest", 32'(state), 32'd2);
    expect_cmd(14, 32'h2000_0000); expect_cmd(17, 32'h4A00_0000);
    expect_cmd(19, 32'h5100_0000);
    clear(4'b1100);
    settle();
    chk("R6 rest issued", 32'(exp_q.size()), 32'd0);

    // R8 interrupt stall masked
    set_mask(3'b100);
    expect_cmd(5, 32'h8500_0000); expect_cmd(9, 32'h1100_0000);
    expect_cmd(10, 32'h1300_0000); expect_cmd(12, 32'h1500_0000);
    push_qw(32'h8500_0000, 32'h1100_0000, 32'h1300_0000, 32'h1500_0000);
    settle();
    chk("R8 int set", 32'(int_flag), 32'd1);
    chk("R8 pis clear", 32'(pis), 32'd0);
    chk("R8 all issued", 32'(exp_q.size()), 32'd0);
    clear(4'b1000);
    set_mask(3'b000);

    // R12 tag error
    @(negedge clk); tag_err = 1'b1; @(negedge clk); tag_err = 1'b0;
    chk("R12 er0 set", 32'(er0), 32'd1);
    push_qw(32'h0000_0000, 32'h0100_0000, 32'h0400_0000, 32'h0500_0000);
    settle();
    chk("R12 stall", 32'(state), 32'd2);
    expect_cmd(0, 32'h0000_0000); expect_cmd(1, 32'h0100_0000);
    expect_cmd(4, 32'h0400_0000); expect_cmd(5, 32'h0500_0000);
    clear(4'b0001);
    settle();
    chk("R12 resumed", 32'(exp_q.size()), 32'd0);
    set_mask(3'b001);
    @(negedge clk); tag_err = 1'b1; @(negedge clk); tag_err = 1'b0;
    chk("R12 masked er0", 32'(er0), 32'd0);
    set_mask(3'b000);

    // R9 instance-1-only command on unit 0
    @(negedge clk);
    b_qw = {32'h0, 32'h0, 32'h0, 32'h0300_0000};
    b_valid = 1'b1;
    @(negedge clk);
    b_valid = 1'b0;
    settle();
    chk("R9 unit0 er1", 32'(b_er1), 32'd1);
    chk("R9 unit0 stall", 32'(b_state), 32'd2);
    chk("R9 unit0 no strobe", 32'(b_strobes), 32'd0);

    summary();
  end
endmodule